// File: doc/BRIEF.md
# Split-Sign Dual Matrix-Vector Engine

This block produces the two vectors that one multiplicative-update iteration of a nonnegative quadratic solver needs. It holds a square matrix H, an offset vector c and the current estimate x. From them it computes a = H⁻x + c⁺ and b = H⁺x + c⁻. H⁺ keeps the nonnegative entries of H, and H⁻ keeps the magnitudes of its negative entries. A small constant is added to the diagonal of both split matrices. The division step and the convergence test are left to the logic around the engine.

Data arrives on one valid/ready stream, in a fixed order. Each matrix entry is split by sign on its way into per-lane memories, and the offset vector is split the same way into two register files. The estimate is stored as it arrives. A start pulse then runs a single column-ordered sweep. Each cycle that sweep reads one column entry for UF rows from both split matrices and fetches x_j once for the whole column. It feeds both products in parallel into accumulators that were preset to the split offsets. A one-cycle done pulse marks the end of the sweep, and both vectors then hold still until the next start.

All values are signed Q16.16 (W = 32, FRAC = 16). The default configuration is N = 8 and UF = 2.

Top module: `dual_symv`

## Requirements
- R1: After reset, done is 0, ldReady is 1, and every element of aVec and bVec is 0.
- R2: A stream beat is taken on a clock edge where ldValid and ldReady are both 1. A full load takes N·N + 2N beats in this order: H row by row (row index outer, column index inner), then c[0..N-1], then x[0..N-1]. The beat after the last x begins a new load at H[0][0].
- R3: A matrix entry v with v ≥ 0 is stored as v in the positive matrix and as 0 in the negative matrix. A negative v is stored as 0 in the positive matrix and as −v in the negative matrix, where −(−2^31) saturates to 2^31−1.
- R4: The parameter DELTA is added, with saturation, to the diagonal entries (row = column) of both split matrices.
- R5: The offset vector is split as c⁺ = max(0,c) and c⁻ = max(0,−c), with the same saturation as R3. No DELTA is added to the offsets.
- R6: After a sweep, a[i] = c⁺[i] + Σ_j H⁻[i][j]·x[j] and b[i] = c⁻[i] + Σ_j H⁺[i][j]·x[j]. Element i is held in bits [32i+31:32i] of aVec and bVec, and the terms are added in increasing column order j.
- R7: Each product is formed at full width, then 2^15 is added and the result is shifted right arithmetically by 16 and saturated to 32 bits. Each accumulation step saturates to [−2^31, 2^31−1].
- R8: start is ignored unless the engine is idle, at least one full load has completed, and no partial load is pending.
- R9: When start is accepted on edge t, done is 1 for exactly one cycle: the cycle after edge t + N·N/UF + 2.
- R10: ldReady is 0 from the start edge until the edge that raises done. Beats offered while ldReady is 0 are not taken.
- R11: aVec and bVec do not change while the engine is idle, and this includes during a full load.
- R12: A second start with no new load between gives the same vectors, because the accumulators are preset again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Load beat valid |
| ldReady | output | 1 | Engine can take a load beat or a start |
| ldData | input | W | Load beat data, signed Q16.16 |
| start | input | 1 | Begin a sweep |
| done | output | 1 | One-cycle pulse when both vectors are complete |
| aVec | output | N·W | H⁻x + c⁺, element i at bits [W·i+W−1 : W·i] |
| bVec | output | N·W | H⁺x + c⁻, element i at bits [W·i+W−1 : W·i] |

## Verification
Edge t is the edge that samples start. The next edge presets the accumulators, the N·N/UF edges after that issue memory reads, and one more edge folds the last column. done is therefore due right after edge t + N·N/UF + 2. The bench counts edges from the start edge and samples done and ldReady at each falling edge, so each sample sees registered state that has settled. It compares every element of both vectors against an arithmetic model at the falling edge where done is seen. It checks that done has fallen again one cycle later.

// File: rtl/dsymv_pkg.sv
package dsymv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRESET,
    ST_SWEEP,
    ST_DRAIN
  } engState_t;

  typedef enum logic [1:0] {
    LD_MAT,
    LD_OFS,
    LD_EST
  } ldPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic preset;   // load accumulators with split offsets
    logic rdEn;     // read one column slice for UF rows
    logic wrMat;    // write a split matrix entry
    logic wrOfs;    // write a split offset entry
    logic wrEst;    // write an estimate entry
  } engStrobe_t;

endpackage

// File: rtl/dsymv_ctrl.sv
module dsymv_ctrl
  import dsymv_pkg::*;
#(
  parameter int N  = 8,
  parameter int UF = 2,
  localparam int NG = N / UF,
  localparam int RW = (N > 1) ? $clog2(N) : 1,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ldValid,
  input  logic          start,
  output logic          ldReady,
  output logic          done,
  output engStrobe_t    stb,
  output logic [RW-1:0] ldRow,
  output logic [RW-1:0] ldCol,
  output logic [GW-1:0] rdGrp,
  output logic [RW-1:0] rdCol
);

  engState_t state;
  ldPhase_t  ldPhase;
  logic      loaded;
  logic      accept;
  logic      loadIdle;
  logic      doneReg;

  assign ldReady  = (state == ST_IDLE);
  assign accept   = ldValid && ldReady;
  assign loadIdle = (ldPhase == LD_MAT) && (ldRow == '0) && (ldCol == '0);

  // load sequencing: matrix row-major, then offsets, then estimate
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldPhase <= LD_MAT;
      ldRow   <= '0;
      ldCol   <= '0;
      loaded  <= 1'b0;
    end else if (accept) begin
      case (ldPhase)
        LD_MAT: begin
          if (ldCol == RW'(N - 1)) begin
            ldCol <= '0;
            if (ldRow == RW'(N - 1)) begin
              ldRow   <= '0;
              ldPhase <= LD_OFS;
            end else begin
              ldRow <= ldRow + 1'b1;
            end
          end else begin
            ldCol <= ldCol + 1'b1;
          end
        end
        LD_OFS: begin
          if (ldRow == RW'(N - 1)) begin
            ldRow   <= '0;
            ldPhase <= LD_EST;
          end else begin
            ldRow <= ldRow + 1'b1;
          end
        end
        default: begin
          if (ldRow == RW'(N - 1)) begin
            ldRow   <= '0;
            ldPhase <= LD_MAT;
            loaded  <= 1'b1;
          end else begin
            ldRow <= ldRow + 1'b1;
          end
        end
      endcase
    end
  end

  // sweep sequencing: groups of UF rows inside each column
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rdGrp   <= '0;
      rdCol   <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= (state == ST_DRAIN);
      case (state)
        ST_IDLE: begin
          if (start && loaded && loadIdle) state <= ST_PRESET;
        end
        ST_PRESET: begin
          rdGrp <= '0;
          rdCol <= '0;
          state <= ST_SWEEP;
        end
        ST_SWEEP: begin
          if (rdGrp == GW'(NG - 1)) begin
            rdGrp <= '0;
            if (rdCol == RW'(N - 1)) begin
              rdCol <= '0;
              state <= ST_DRAIN;
            end else begin
              rdCol <= rdCol + 1'b1;
            end
          end else begin
            rdGrp <= rdGrp + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done      = doneReg;
  assign stb.preset = (state == ST_PRESET);
  assign stb.rdEn   = (state == ST_SWEEP);
  assign stb.wrMat  = accept && (ldPhase == LD_MAT);
  assign stb.wrOfs  = accept && (ldPhase == LD_OFS);
  assign stb.wrEst  = accept && (ldPhase == LD_EST);

endmodule

// File: rtl/dsymv_dp.sv
module dsymv_dp
  import dsymv_pkg::*;
#(
  parameter int N     = 8,
  parameter int UF    = 2,
  parameter int W     = 32,
  parameter int FRAC  = 16,
  parameter int DELTA = 256,
  localparam int NG    = N / UF,
  localparam int RW    = (N > 1) ? $clog2(N) : 1,
  localparam int GW    = (NG > 1) ? $clog2(NG) : 1,
  localparam int LW    = (UF > 1) ? $clog2(UF) : 1,
  localparam int DEPTH = NG * N,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  engStrobe_t     stb,
  input  logic [W-1:0]   ldData,
  input  logic [RW-1:0]  ldRow,
  input  logic [RW-1:0]  ldCol,
  input  logic [GW-1:0]  rdGrp,
  input  logic [RW-1:0]  rdCol,
  output logic [N*W-1:0] aVec,
  output logic [N*W-1:0] bVec
);

  localparam logic [W-1:0] MAXV    = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV    = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] DELTA_W = W'(DELTA);
  localparam logic signed [2*W-1:0] RND = (2*W)'(1) << (FRAC - 1);

  function automatic logic [W-1:0] satAdd(input logic [W-1:0] x1, input logic [W-1:0] x2);
    logic [W:0] s;
    s = {x1[W-1], x1} + {x2[W-1], x2};
    if (s[W] != s[W-1]) return s[W] ? MINV : MAXV;
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] satNeg(input logic [W-1:0] v);
    if (v == MINV) return MAXV;
    return '0 - v;
  endfunction

  function automatic logic [W-1:0] mulRound(input logic [W-1:0] h, input logic [W-1:0] x);
    logic signed [2*W-1:0] p;
    logic signed [2*W-1:0] sh;
    logic [W:0] hi;
    p  = $signed(h) * $signed(x);
    sh = (p + RND) >>> FRAC;
    hi = sh[2*W-1:W-1];
    if ((&hi) || !(|hi)) return sh[W-1:0];
    return sh[2*W-1] ? MINV : MAXV;
  endfunction

  // ---------------- sign split on the load path ----------------
  logic [W-1:0]  posPart, negPart, splitP, splitN;
  logic          isDiag;
  logic [LW-1:0] wrLane;
  logic [AW-1:0] wrAddr, rdAddr;

  assign posPart = ldData[W-1] ? '0 : ldData;
  assign negPart = ldData[W-1] ? satNeg(ldData) : '0;
  assign isDiag  = (ldRow == ldCol);
  assign splitP  = isDiag ? satAdd(posPart, DELTA_W) : posPart;
  assign splitN  = isDiag ? satAdd(negPart, DELTA_W) : negPart;
  assign wrLane  = LW'(int'(ldRow) % UF);
  assign wrAddr  = AW'((int'(ldRow) / UF) * N + int'(ldCol));
  assign rdAddr  = AW'(int'(rdGrp) * N + int'(rdCol));

  // offsets and estimate
  logic [W-1:0] cPos [N];
  logic [W-1:0] cNeg [N];
  logic [W-1:0] xMem [N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < N; r++) begin
        cPos[r] <= '0;
        cNeg[r] <= '0;
        xMem[r] <= '0;
      end
    end else begin
      if (stb.wrOfs) begin
        cPos[ldRow] <= posPart;
        cNeg[ldRow] <= negPart;
      end
      if (stb.wrEst) xMem[ldRow] <= ldData;
    end
  end

  // ---------------- fold pipeline stage ----------------
  logic          foldValid;
  logic [GW-1:0] grpReg;
  logic [W-1:0]  xReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      foldValid <= 1'b0;
      grpReg    <= '0;
      xReg      <= '0;
    end else begin
      foldValid <= stb.rdEn;
      if (stb.rdEn) begin
        grpReg <= rdGrp;
        xReg   <= xMem[rdCol];  // one fetch per column slice
      end
    end
  end

  logic [UF-1:0][W-1:0] prodA;
  logic [UF-1:0][W-1:0] prodB;

  for (genvar k = 0; k < UF; k++) begin : g_lane
    logic [W-1:0] memP [DEPTH];
    logic [W-1:0] memN [DEPTH];
    logic [W-1:0] rdP;
    logic [W-1:0] rdN;

    always_ff @(posedge clk) begin
      if (stb.wrMat && (wrLane == LW'(k))) begin
        memP[wrAddr] <= splitP;
        memN[wrAddr] <= splitN;
      end
      if (stb.rdEn) begin
        rdP <= memP[rdAddr];
        rdN <= memN[rdAddr];
      end
    end

    assign prodA[k] = mulRound(rdN, xReg);
    assign prodB[k] = mulRound(rdP, xReg);
  end

  // ---------------- accumulators ----------------
  logic [W-1:0] accA [N];
  logic [W-1:0] accB [N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < N; r++) begin
        accA[r] <= '0;
        accB[r] <= '0;
      end
    end else if (stb.preset) begin
      for (int r = 0; r < N; r++) begin
        accA[r] <= cPos[r];
        accB[r] <= cNeg[r];
      end
    end else if (foldValid) begin
      for (int r = 0; r < N; r++) begin
        if (grpReg == GW'(r / UF)) begin
          accA[r] <= satAdd(accA[r], prodA[r % UF]);
          accB[r] <= satAdd(accB[r], prodB[r % UF]);
        end
      end
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_out
    assign aVec[r*W +: W] = accA[r];
    assign bVec[r*W +: W] = accB[r];
  end

endmodule

// File: rtl/dual_symv.sv
module dual_symv
  import dsymv_pkg::*;
#(
  parameter int N     = 8,
  parameter int UF    = 2,
  parameter int W     = 32,
  parameter int FRAC  = 16,
  parameter int DELTA = 256,
  localparam int NG = N / UF,
  localparam int RW = (N > 1) ? $clog2(N) : 1,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           ldValid,
  output logic           ldReady,
  input  logic [W-1:0]   ldData,
  input  logic           start,
  output logic           done,
  output logic [N*W-1:0] aVec,
  output logic [N*W-1:0] bVec
);

  engStrobe_t    stb;
  logic [RW-1:0] ldRow, ldCol, rdCol;
  logic [GW-1:0] rdGrp;

  dsymv_ctrl #(.N(N), .UF(UF)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ldValid(ldValid),
    .start  (start),
    .ldReady(ldReady),
    .done   (done),
    .stb    (stb),
    .ldRow  (ldRow),
    .ldCol  (ldCol),
    .rdGrp  (rdGrp),
    .rdCol  (rdCol)
  );

  dsymv_dp #(.N(N), .UF(UF), .W(W), .FRAC(FRAC), .DELTA(DELTA)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .ldData(ldData),
    .ldRow (ldRow),
    .ldCol (ldCol),
    .rdGrp (rdGrp),
    .rdCol (rdCol),
    .aVec  (aVec),
    .bVec  (bVec)
  );

endmodule

// File: rtl/dual_symv_chk.sv
module dual_symv_chk #(
  parameter int N  = 8,
  parameter int UF = 2,
  parameter int W  = 32,
  localparam int SWEEP = N * N / UF + 2,
  localparam int CW    = $clog2(SWEEP + 2) + 1
) (
  input logic           clk,
  input logic           rstN,
  input logic           ldReady,
  input logic           done,
  input logic [N*W-1:0] aVec,
  input logic [N*W-1:0] bVec
);

  logic [CW-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= '0;
    else       busyCnt <= ldReady ? '0 : busyCnt + 1'b1;
  end

  // R9: done lasts a single cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: done arrives a fixed number of busy cycles after start
  p_done_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCnt == CW'(SWEEP)));

  // R10: ready returns only together with done
  p_ready_return_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ldReady) |-> done);

  // R10: done is never raised while still busy
  p_done_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ldReady);

  // R11: results stay put while idle
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ldReady && $past(ldReady)) |-> ($stable(aVec) && $stable(bVec)));

endmodule

bind dual_symv dual_symv_chk #(.N(N), .UF(UF), .W(W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .ldReady(ldReady),
  .done   (done),
  .aVec   (aVec),
  .bVec   (bVec)
);

// File: tb/tb_dual_symv.sv
`timescale 1ns/1ps
module tb_dual_symv;

  localparam int N     = 8;
  localparam int UF    = 2;
  localparam int W     = 32;
  localparam int FRAC  = 16;
  localparam int DELTA = 256;
  localparam int K     = N * N / UF;
  localparam int TOT   = N * N + 2 * N;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           ldValid = 1'b0;
  logic           ldReady;
  logic [W-1:0]   ldData = '0;
  logic           start = 1'b0;
  logic           done;
  logic [N*W-1:0] aVec, bVec;

  always #2 clk = ~clk;

  dual_symv #(.N(N), .UF(UF), .W(W), .FRAC(FRAC), .DELTA(DELTA)) dut (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldReady(ldReady),
    .ldData(ldData), .start(start), .done(done), .aVec(aVec), .bVec(bVec)
  );

  int nVec = 0;
  int nBad = 0;
  longint hM [N][N];
  longint cV [N];
  longint xV [N];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat32(input longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic longint splitOf(input longint v, input bit neg, input bit diag);
    longint b;
    if (neg) b = (v < 0) ? sat32(-v) : 0;
    else     b = (v >= 0) ? v : 0;
    if (diag) b = sat32(b + DELTA);
    return b;
  endfunction

  function automatic longint mulRnd(input longint h, input longint x);
    return sat32((h * x + (64'sd1 <<< (FRAC - 1))) >>> FRAC);
  endfunction

  function automatic longint beatOf(input int idx);
    if (idx < N * N) return hM[idx / N][idx % N];
    if (idx < N * N + N) return cV[idx - N * N];
    return xV[idx - N * N - N];
  endfunction

  function automatic longint elemOf(input logic [N*W-1:0] vec, input int i);
    return longint'($signed(vec[i*W +: W]));
  endfunction

  task automatic loadBeats(input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      ldValid = 1'b1;
      ldData  = W'(beatOf(i));
      @(posedge clk);
      @(negedge clk);
    end
    ldValid = 1'b0;
  endtask

  task automatic runSweep(input string tag);
    int n;
    bit readyLeak;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start   = 1'b0;
    ldValid = 1'b1;             // offered while busy, must not be taken
    ldData  = 32'hDEAD_BEEF;
    n = 0;
    readyLeak = 0;
    while (!done && n < 200) begin
      if (ldReady) readyLeak = 1;
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    ldValid = 1'b0;
    check(!readyLeak, {"R10 ready low while busy ", tag}, readyLeak, 0);
    check(n == K + 2, {"R9 done latency ", tag}, n, K + 2);
    check(ldReady == 1'b1, {"R10 ready back at done ", tag}, ldReady, 1);
    @(negedge clk);
    check(done == 1'b0, {"R9 done one cycle ", tag}, done, 0);
  endtask

  task automatic checkResults(input string tag);
    for (int i = 0; i < N; i++) begin
      longint ea, eb;
      ea = splitOf(cV[i], 0, 0);
      eb = splitOf(cV[i], 1, 0);
      for (int j = 0; j < N; j++) begin
        ea = sat32(ea + mulRnd(splitOf(hM[i][j], 1, i == j), xV[j]));
        eb = sat32(eb + mulRnd(splitOf(hM[i][j], 0, i == j), xV[j]));
      end
      check(elemOf(aVec, i) == ea, {"a ", tag}, elemOf(aVec, i), ea);
      check(elemOf(bVec, i) == eb, {"b ", tag}, elemOf(bVec, i), eb);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nVec++;
    nBad++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    logic [N*W-1:0] snapA, snapB;
    bit sawDone, readyDrop;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(ldReady == 1'b1, "R1 ready after reset", ldReady, 1);
    check(aVec == '0, "R1 aVec zero", aVec == '0, 1);
    check(bVec == '0, "R1 bVec zero", bVec == '0, 1);

    // R8: start with nothing loaded
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sawDone = 0; readyDrop = 0;
    repeat (K + 8) begin
      @(negedge clk);
      if (done) sawDone = 1;
      if (!ldReady) readyDrop = 1;
    end
    check(!sawDone && !readyDrop, "R8 start before any load ignored", sawDone | readyDrop, 0);

    // case 1: moderate random, positive estimate
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) hM[r][c] = longint'($signed($urandom()) >>> 13);
      cV[r] = longint'($signed($urandom()) >>> 12);
      xV[r] = longint'($urandom() % (2 << FRAC));
    end
    loadBeats(0, 5);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sawDone = 0; readyDrop = 0;
    repeat (K + 8) begin
      @(negedge clk);
      if (done) sawDone = 1;
      if (!ldReady) readyDrop = 1;
    end
    check(!sawDone && !readyDrop, "R8 start during partial load ignored", sawDone | readyDrop, 0);
    loadBeats(5, TOT);
    runSweep("case1");
    checkResults("R2 R3 R5 R6 case1");

    // R12: rerun without reload
    runSweep("rerun");
    checkResults("R12 rerun same vectors");

    // case 2: zero matrix, diagonal regularizer only; full reload while idle
    snapA = aVec;
    snapB = bVec;
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) hM[r][c] = 0;
      cV[r] = longint'($signed($urandom()) >>> 10);
      xV[r] = longint'($signed($urandom()) >>> 13);
    end
    loadBeats(0, TOT);
    @(negedge clk);
    check(aVec == snapA && bVec == snapB, "R11 vectors held across load", (aVec == snapA) && (bVec == snapB), 1);
    runSweep("case2");
    checkResults("R4 R5 case2");

    // case 3: extreme entries, saturation
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        case ((r + c) % 3)
          0: hM[r][c] = -64'sd2147483648;
          1: hM[r][c] = 64'sd2147483647;
          default: hM[r][c] = 64'sh7FFF_0000;
        endcase
      end
      cV[r] = (r % 2) ? 64'sd2147483647 : -64'sd2147483648;
      xV[r] = (r % 2) ? longint'(100 <<< FRAC) : -longint'(100 <<< FRAC);
    end
    loadBeats(0, TOT);
    runSweep("case3");
    checkResults("R3 R4 R7 case3 saturation");

    // case 4: half-LSB products, rounding
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) hM[r][c] = ((r + c) % 2) ? 1 : -1;
      cV[r] = 0;
      case (r % 4)
        0: xV[r] = 64'sh8000;
        1: xV[r] = -64'sh8000;
        2: xV[r] = 64'sh18000;
        default: xV[r] = -64'sh18000;
      endcase
    end
    loadBeats(0, TOT);
    runSweep("case4");
    checkResults("R7 case4 rounding");

    // case 5: full-range random
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) hM[r][c] = longint'($signed($urandom()));
      cV[r] = longint'($signed($urandom()));
      xV[r] = longint'($signed($urandom()) >>> 14);
    end
    loadBeats(0, TOT);
    runSweep("case5");
    checkResults("R2 R6 R7 case5");

    finishRun();
  end

endmodule